// File: doc/BRIEF.md
# Register Command Packet Engine

This block sits between a network front end and an on-chip register bus. It takes a single command packet as a stream of 32-bit words, decodes the command, runs it word by word against a synchronous register port, and returns a reply packet as a second word stream. There are three command families. A burst read fetches N consecutive registers. A burst overwrite stores N payload words into consecutive registers. A masked update reads each register, combines it with a mask word from the packet by AND, OR or XOR, and writes the result back to the same register.

The whole packet is taken in and checked before any bus access starts. Payload words are held in a local word store sized for the largest allowed burst. This lets a malformed packet be rejected with no write at all. Every reply starts with the command's start address echoed back. Bit 31 of that word is a failure flag. Read data follows the echo only when a read succeeds. Input and output use valid/ready/last handshakes. The engine works on one packet at a time and does not accept the next packet until the current reply has been fully sent.

The controller is a state machine with these states:
- `ST_OPCODE`, `ST_COUNT`, `ST_ADDR`: header intake.
- `ST_PAYLOAD`: payload intake.
- `ST_DRAIN`: discards surplus or rejected words.
- `ST_RD_ISSUE`, `ST_RD_LAST`: burst read.
- `ST_WR`: burst overwrite.
- `ST_RMW_RD`, `ST_RMW_WR`: masked update.
- `ST_ECHO`, `ST_DATA`: reply.

Its transitions are:
- Header intake steps opcode → count → address.
- From the address word it goes to payload (write or masked update with N > 0), drain (surplus words, or a rejected header), execution (a complete header-only packet), or echo (failure, or N = 0).
- Payload goes to execution on the final word, or to drain if more words follow. A packet that ends too early goes to echo.
- Drain goes to execution or echo when the last word arrives.
- Each execution state loops per word and then goes to echo.
- Echo goes to data for a successful read with N > 0, and otherwise returns to opcode intake.
- Data returns to opcode intake after the final word.

Top module: `regcmd_engine`

## Requirements
- R1: A packet is a word stream whose first three words are, in order, the opcode, the word count N and the start address. Out of reset `in_ready` is 1, `out_valid` is 0 and neither bus strobe is active. While `in_ready` is 1 no bus strobe is active.
- R2: Opcode 1 (read) issues N bus reads at consecutive word addresses. The reply is the echo word followed by the N read values in address order, with `out_last` on the final word.
- R3: Opcode 2 (overwrite) writes the N payload words that follow the header to consecutive addresses, in order.
- R4: Opcodes 3, 4 and 5 handle each word in turn. Each word takes one read cycle and then, in the next cycle, a write to the same address. The write value is the read value combined with the matching payload mask by AND (3), OR (4) or XOR (5).
- R5: The first reply word carries start-address bits 30:0 in bits 30:0 and the failure flag in bit 31. The echo word is the only reply word, and carries `out_last`, for every write, for every masked update, for N = 0 and for every failure.
- R6: An opcode of 0 or above 5 is a failure. The rest of the packet is discarded up to its last word and no bus access occurs.
- R7: A packet that ends before its header, or before the N payload words required by opcodes 2 to 5, is a failure. No bus access occurs.
- R8: A count N greater than parameter MAX_N (default 16) is a failure. No bus access occurs.
- R9: A count of zero with a valid opcode performs no bus access. The reply is the echo word alone, with bit 31 clear.
- R10: Words after the header (for a read) or after the N payload words (for other opcodes) are accepted and ignored, and do not affect the bus.
- R11: `in_ready` is 0 while a reply word is offered. A reply word that is offered and not taken keeps its value and `out_last` until it is taken.
- R12: The bus address is the low AW bits of the start address plus the element index. Read data is taken one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Command packet word |
| in_valid | input | 1 | Command word valid |
| in_last | input | 1 | Final word of the command packet |
| in_ready | output | 1 | Engine can take a command word |
| out_data | output | 32 | Reply word |
| out_valid | output | 1 | Reply word valid |
| out_last | output | 1 | Final word of the reply |
| out_ready | input | 1 | Receiver takes the reply word |
| bus_addr | output | AW | Register word address |
| bus_rd_en | output | 1 | Read strobe; data expected one cycle later |
| bus_rd_data | input | 32 | Read data, one cycle after the strobe |
| bus_wr_en | output | 1 | Write strobe |
| bus_wr_data | output | 32 | Write data |

## Verification
The hardest case to reach is a packet that fails after some payload has already been stored: an overwrite that ends one word short. The bench builds it by sending a complete header announcing three words and then asserting last on the second data word. It confirms that the bus model's write counter has not moved and that the echo carries bit 31. A second awkward case is a reply stalled in the middle of a read burst. The bench reaches it by toggling `out_ready` every cycle while collecting the read reply, and checks that a held word does not change.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_READ  = 3'd1,
        OPC_WRITE = 3'd2,
        OPC_AND   = 3'd3,
        OPC_OR    = 3'd4,
        OPC_XOR   = 3'd5
    } opc_e;

    typedef enum logic [3:0] {
        ST_OPCODE,
        ST_COUNT,
        ST_ADDR,
        ST_PAYLOAD,
        ST_DRAIN,
        ST_RD_ISSUE,
        ST_RD_LAST,
        ST_WR,
        ST_RMW_RD,
        ST_RMW_WR,
        ST_ECHO,
        ST_DATA
    } state_e;

    function automatic logic opc_known(input logic [WORD_W-1:0] w);
        return (w >= 32'd1) && (w <= 32'd5);
    endfunction

endpackage

// File: rtl/regcmd_wordbuf.sv
module regcmd_wordbuf #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && (waddr == IW'(g))) begin
                ent[g] <= wdata;
            end
        end
    end

    assign rdata = ent[raddr];

endmodule

// File: rtl/regcmd_combine.sv
module regcmd_combine
    import regcmd_pkg::*;
#(
    parameter int W = 32
) (
    input  opc_e         op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (op)
            OPC_AND: res = cur & mask;
            OPC_OR:  res = cur | mask;
            OPC_XOR: res = cur ^ mask;
            default: res = mask;
        endcase
    end

endmodule

// File: rtl/regcmd_engine.sv
module regcmd_engine
    import regcmd_pkg::*;
#(
    parameter int AW    = 16,
    parameter int MAX_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rd_en,
    input  logic [WORD_W-1:0] bus_rd_data,
    output logic              bus_wr_en,
    output logic [WORD_W-1:0] bus_wr_data
);

    localparam int IW = (MAX_N > 1) ? $clog2(MAX_N) : 1;
    localparam int CW = $clog2(MAX_N + 1);

    state_e            state, state_d;
    opc_e              op;
    logic              op_bad, too_big, fail;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] addr_word;
    logic              cap_vld;
    logic [IW-1:0]     cap_idx;

    logic              in_fire, out_fire;
    logic              last_idx, hdr_err, need_pl, echo_last;
    state_e            exec_st;
    logic [WORD_W-1:0] buf_rdata, buf_wdata, rmw_val;
    logic [IW-1:0]     buf_waddr;
    logic              buf_we;

    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign last_idx  = (CW'(idx) == (cnt - CW'(1)));
    assign hdr_err   = op_bad || too_big;
    assign need_pl   = (op != OPC_READ) && (cnt != '0);
    assign echo_last = fail || (op != OPC_READ) || (cnt == '0);

    // first execution state for the latched command
    always_comb begin
        if (cnt == '0) begin
            exec_st = ST_ECHO;
        end else begin
            unique case (op)
                OPC_READ:  exec_st = ST_RD_ISSUE;
                OPC_WRITE: exec_st = ST_WR;
                default:   exec_st = ST_RMW_RD;
            endcase
        end
    end

    // payload store: filled by intake, or by read capture
    assign buf_we    = ((state == ST_PAYLOAD) && in_fire) || cap_vld;
    assign buf_waddr = cap_vld ? cap_idx : idx;
    assign buf_wdata = cap_vld ? bus_rd_data : in_data;

    regcmd_wordbuf #(.DEPTH(MAX_N), .W(WORD_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (idx),
        .rdata (buf_rdata)
    );

    regcmd_combine #(.W(WORD_W)) u_comb (
        .op   (op),
        .cur  (bus_rd_data),
        .mask (buf_rdata),
        .res  (rmw_val)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_OPCODE: if (in_fire) state_d = in_last ? ST_ECHO : ST_COUNT;
            ST_COUNT:  if (in_fire) state_d = in_last ? ST_ECHO : ST_ADDR;
            ST_ADDR: begin
                if (in_fire) begin
                    if (in_last)      state_d = (hdr_err || need_pl) ? ST_ECHO : exec_st;
                    else if (hdr_err) state_d = ST_DRAIN;
                    else if (need_pl) state_d = ST_PAYLOAD;
                    else              state_d = ST_DRAIN;
                end
            end
            ST_PAYLOAD: begin
                if (in_fire) begin
                    if (last_idx)     state_d = in_last ? exec_st : ST_DRAIN;
                    else if (in_last) state_d = ST_ECHO;
                end
            end
            ST_DRAIN:    if (in_fire && in_last) state_d = fail ? ST_ECHO : exec_st;
            ST_RD_ISSUE: if (last_idx) state_d = ST_RD_LAST;
            ST_RD_LAST:  state_d = ST_ECHO;
            ST_WR:       if (last_idx) state_d = ST_ECHO;
            ST_RMW_RD:   state_d = ST_RMW_WR;
            ST_RMW_WR:   state_d = last_idx ? ST_ECHO : ST_RMW_RD;
            ST_ECHO:     if (out_fire) state_d = echo_last ? ST_OPCODE : ST_DATA;
            ST_DATA:     if (out_fire && last_idx) state_d = ST_OPCODE;
            default:     state_d = ST_OPCODE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OPCODE;
        else        state <= state_d;
    end

    // command and index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op        <= OPC_NONE;
            op_bad    <= 1'b0;
            too_big   <= 1'b0;
            fail      <= 1'b0;
            cnt       <= '0;
            idx       <= '0;
            addr_word <= '0;
            cap_vld   <= 1'b0;
            cap_idx   <= '0;
        end else begin
            cap_vld <= (state == ST_RD_ISSUE);
            cap_idx <= idx;
            unique case (state)
                ST_OPCODE: begin
                    idx <= '0;
                    if (in_fire) begin
                        op        <= opc_known(in_data) ? opc_e'(in_data[2:0]) : OPC_NONE;
                        op_bad    <= !opc_known(in_data);
                        too_big   <= 1'b0;
                        fail      <= in_last;
                        cnt       <= '0;
                        addr_word <= '0;
                    end
                end
                ST_COUNT: begin
                    if (in_fire) begin
                        too_big <= (in_data > WORD_W'(MAX_N));
                        cnt     <= (in_data > WORD_W'(MAX_N)) ? '0 : in_data[CW-1:0];
                        fail    <= in_last;
                    end
                end
                ST_ADDR: begin
                    if (in_fire) begin
                        addr_word <= in_data;
                        fail      <= hdr_err || (in_last && need_pl);
                    end
                end
                ST_PAYLOAD: begin
                    if (in_fire) begin
                        idx <= last_idx ? '0 : idx + IW'(1);
                        if (!last_idx && in_last) fail <= 1'b1;
                    end
                end
                ST_RD_ISSUE, ST_WR, ST_RMW_WR: begin
                    if (!last_idx) idx <= idx + IW'(1);
                end
                ST_ECHO: idx <= '0;
                ST_DATA: if (out_fire) idx <= idx + IW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready    = 1'b0;
        out_valid   = 1'b0;
        out_last    = 1'b0;
        out_data    = buf_rdata;
        bus_rd_en   = 1'b0;
        bus_wr_en   = 1'b0;
        bus_wr_data = buf_rdata;
        bus_addr    = addr_word[AW-1:0] + AW'(idx);
        unique case (state)
            ST_OPCODE, ST_COUNT, ST_ADDR, ST_PAYLOAD, ST_DRAIN: in_ready = 1'b1;
            ST_RD_ISSUE: bus_rd_en = 1'b1;
            ST_RD_LAST:  ;
            ST_WR:       bus_wr_en = 1'b1;
            ST_RMW_RD:   bus_rd_en = 1'b1;
            ST_RMW_WR: begin
                bus_wr_en   = 1'b1;
                bus_wr_data = rmw_val;
            end
            ST_ECHO: begin
                out_valid = 1'b1;
                out_last  = echo_last;
                out_data  = {fail, addr_word[WORD_W-2:0]};
            end
            ST_DATA: begin
                out_valid = 1'b1;
                out_last  = last_idx;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/regcmd_engine_chk.sv
module regcmd_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_last,
    input logic [31:0]   out_data,
    input logic          bus_rd_en,
    input logic          bus_wr_en,
    input logic [AW-1:0] bus_addr
);

    // R1: no bus strobe while packet words are still being taken
    p_no_bus_in_intake_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!bus_rd_en && !bus_wr_en));

    // R4: a read and a write never share a cycle
    p_rd_wr_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd_en, bus_wr_en}));

    // R12: back-to-back reads step the address by one word
    p_rd_addr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && $past(bus_rd_en)) |-> (bus_addr == $past(bus_addr) + AW'(1)));

    // R12: back-to-back writes step the address by one word
    p_wr_addr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && $past(bus_wr_en)) |-> (bus_addr == $past(bus_addr) + AW'(1)));

    // R11: no intake while a reply word is offered
    p_no_intake_in_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R11: a stalled reply word is held
    p_reply_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R5: last only marks an offered word
    p_last_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

bind regcmd_engine regcmd_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_data  (out_data),
    .bus_rd_en (bus_rd_en),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr)
);

// File: tb/regcmd_engine_test.sv
`timescale 1ns/1ps
module regcmd_engine_test;

    localparam int AW    = 16;
    localparam int MAX_N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic [31:0]   out_data;
    logic          out_valid;
    logic          out_last;
    logic          out_ready = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_rd_en;
    logic [31:0]   bus_rd_data;
    logic          bus_wr_en;
    logic [31:0]   bus_wr_data;

    always #4 clk = ~clk;

    regcmd_engine #(.AW(AW), .MAX_N(MAX_N)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .bus_addr(bus_addr), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data)
    );

    // register bus model: one cycle read latency
    logic [31:0]   mem [256];
    int            wr_cnt = 0;
    int            rd_cnt = 0;
    logic [AW-1:0] last_wr_addr = '0;

    always @(posedge clk) begin
        if (bus_wr_en) begin
            mem[bus_addr[7:0]] <= bus_wr_data;
            wr_cnt <= wr_cnt + 1;
            last_wr_addr <= bus_addr;
        end
        if (bus_rd_en) begin
            bus_rd_data <= mem[bus_addr[7:0]];
            rd_cnt <= rd_cnt + 1;
        end
    end

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] pkt [32];
    logic [31:0] rep [32];
    logic [31:0] exp_w [32];
    int          rep_n;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send_pkt(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pkt[k];
            in_last  = (k == n - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic get_reply(input bit stall);
        bit          done = 1'b0;
        int          cyc = 0;
        bit          held = 1'b0;
        logic [31:0] held_d = '0;
        rep_n = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (held && out_data !== held_d)
                chk(1'b0, "R11 held word changed", out_data, held_d);
            out_ready = stall ? cyc[0] : 1'b1;
            if (out_valid && in_ready) chk(1'b0, "R11 intake during reply", 32'd1, 32'd0);
            held   = out_valid && !out_ready;
            held_d = out_data;
            if (out_valid && out_ready) begin
                rep[rep_n] = out_data;
                rep_n++;
                done = out_last;
            end
        end
        if (!done) chk(1'b0, "reply timeout", 32'(rep_n), 32'd0);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic cmp_reply(input int n, input string req);
        chk(rep_n == n, req, 32'(rep_n), 32'(n));
        for (int k = 0; k < n && k < rep_n; k++)
            chk(rep[k] === exp_w[k], req, rep[k], exp_w[k]);
    endtask

    task automatic t_reset;
        chk(in_ready === 1'b1 && out_valid === 1'b0 && !bus_rd_en && !bus_wr_en,
            "R1 reset state", {29'd0, in_ready, out_valid, bus_wr_en}, 32'h4);
    endtask

    task automatic t_write;
        pkt[0] = 2; pkt[1] = 3; pkt[2] = 32'h10;
        pkt[3] = 32'h11111111; pkt[4] = 32'h22222222; pkt[5] = 32'h33333333;
        send_pkt(6);
        get_reply(1'b0);
        exp_w[0] = 32'h10;
        cmp_reply(1, "R5 write echo");
        chk(mem[8'h10] === 32'h11111111, "R3 word0", mem[8'h10], 32'h11111111);
        chk(mem[8'h11] === 32'h22222222, "R3 word1", mem[8'h11], 32'h22222222);
        chk(mem[8'h12] === 32'h33333333, "R3 word2", mem[8'h12], 32'h33333333);
    endtask

    task automatic t_read_stall;
        pkt[0] = 1; pkt[1] = 3; pkt[2] = 32'h10;
        send_pkt(3);
        get_reply(1'b1);
        exp_w[0] = 32'h10; exp_w[1] = 32'h11111111;
        exp_w[2] = 32'h22222222; exp_w[3] = 32'h33333333;
        cmp_reply(4, "R2 read reply with stalls R11");
    endtask

    task automatic t_rmw;
        pkt[0] = 3; pkt[1] = 1; pkt[2] = 32'h10; pkt[3] = 32'h0000FFFF;
        send_pkt(4); get_reply(1'b0);
        exp_w[0] = 32'h10; cmp_reply(1, "R4 AND echo");
        chk(mem[8'h10] === 32'h00001111, "R4 AND", mem[8'h10], 32'h00001111);
        pkt[0] = 4; pkt[1] = 1; pkt[2] = 32'h11; pkt[3] = 32'hF0000000;
        send_pkt(4); get_reply(1'b0);
        chk(mem[8'h11] === 32'hF2222222, "R4 OR", mem[8'h11], 32'hF2222222);
        pkt[0] = 5; pkt[1] = 2; pkt[2] = 32'h12; pkt[3] = 32'hFFFFFFFF; pkt[4] = 32'h0;
        send_pkt(5); get_reply(1'b0);
        chk(mem[8'h12] === 32'hCCCCCCCC, "R4 XOR word0", mem[8'h12], 32'hCCCCCCCC);
        chk(mem[8'h13] === 32'hA0000013, "R4 XOR word1", mem[8'h13], 32'hA0000013);
    endtask

    task automatic t_badop;
        int w0 = wr_cnt, r0 = rd_cnt;
        pkt[0] = 7; pkt[1] = 1; pkt[2] = 32'h20; pkt[3] = 32'hDEAD;
        send_pkt(4); get_reply(1'b0);
        exp_w[0] = 32'h80000020; cmp_reply(1, "R6 bad opcode echo");
        chk(wr_cnt == w0 && rd_cnt == r0, "R6 no bus access", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
        chk(mem[8'h20] === 32'hA0000020, "R6 register untouched", mem[8'h20], 32'hA0000020);
    endtask

    task automatic t_short;
        int w0 = wr_cnt;
        pkt[0] = 2; pkt[1] = 3; pkt[2] = 32'h30; pkt[3] = 32'h1; pkt[4] = 32'h2;
        send_pkt(5); get_reply(1'b0);
        exp_w[0] = 32'h80000030; cmp_reply(1, "R7 short payload echo");
        chk(wr_cnt == w0, "R7 no writes", 32'(wr_cnt - w0), 0);
        chk(mem[8'h30] === 32'hA0000030, "R7 register untouched", mem[8'h30], 32'hA0000030);
        pkt[0] = 1;
        send_pkt(1); get_reply(1'b0);
        exp_w[0] = 32'h80000000; cmp_reply(1, "R7 header cut short");
    endtask

    task automatic t_big;
        int r0 = rd_cnt;
        pkt[0] = 1; pkt[1] = MAX_N + 1; pkt[2] = 32'h40;
        send_pkt(3); get_reply(1'b0);
        exp_w[0] = 32'h80000040; cmp_reply(1, "R8 count too large");
        chk(rd_cnt == r0, "R8 no reads", 32'(rd_cnt - r0), 0);
    endtask

    task automatic t_zero;
        int a0 = wr_cnt + rd_cnt;
        pkt[0] = 1; pkt[1] = 0; pkt[2] = 32'h44;
        send_pkt(3); get_reply(1'b0);
        exp_w[0] = 32'h44; cmp_reply(1, "R9 zero count echo");
        chk(wr_cnt + rd_cnt == a0, "R9 no bus access", 32'(wr_cnt + rd_cnt - a0), 0);
    endtask

    task automatic t_extra;
        pkt[0] = 2; pkt[1] = 1; pkt[2] = 32'h50; pkt[3] = 32'h5555AAAA;
        pkt[4] = 32'h1; pkt[5] = 32'h2;
        send_pkt(6); get_reply(1'b0);
        exp_w[0] = 32'h50; cmp_reply(1, "R10 surplus echo");
        chk(mem[8'h50] === 32'h5555AAAA, "R10 payload stored", mem[8'h50], 32'h5555AAAA);
        chk(mem[8'h51] === 32'hA0000051, "R10 surplus ignored", mem[8'h51], 32'hA0000051);
    endtask

    task automatic t_addr;
        pkt[0] = 2; pkt[1] = 1; pkt[2] = 32'h00010060; pkt[3] = 32'h77;
        send_pkt(4); get_reply(1'b0);
        exp_w[0] = 32'h00010060; cmp_reply(1, "R5 echo full address");
        chk(last_wr_addr === 16'h0060, "R12 low address bits", 32'(last_wr_addr), 32'h60);
        chk(mem[8'h60] === 32'h77, "R12 write landed", mem[8'h60], 32'h77);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA0000000 + 32'(i);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read_stall();
        t_rmw();
        t_badop();
        t_short();
        t_big();
        t_zero();
        t_extra();
        t_addr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule